// File: doc/BRIEF.md
# Parallel PRBS Generator and Checker

This block tests a converter data path with a pseudo-random binary sequence. It has two parts. A generator produces one sample-wide word of sequence data on every enabled clock, which stands in for converter samples. A checker receives words of the same width, locks onto the incoming stream and predicts each following word. It flags every word that differs from its prediction.

Both parts use a Fibonacci shift register. Each new bit is the XOR of a tap stage with the last stage. The register advances by a whole sample width of bits in one clock. The register length is never larger than the sample width, so the checker can take its full state from a single received word. It has no training phase.

The checker keeps a saturating count of bad words. After a set number of bad words in a row, it reseeds itself from the incoming data. This lets it follow a source that has restarted or jumped to another point in the sequence.

Top module: `prbs_gen_chk`

## Requirements
- R1: While reset is held, and until the first enabled clock, gen_data is zero and gen_valid, chk_locked, chk_err and chk_err_count are zero. The generator register starts at all ones, so the first word follows from that seed.
- R2: Length and tap are one of the pairs (7,6), (9,5), (15,14), (23,18) or (31,28). The length must not exceed SAMPLE_W, and SAMPLE_W lies in 12..16. Any other setting is flagged at time zero.
- R3: On a clock with gen_en high, the generator computes SAMPLE_W new bits. Each bit is the XOR of stage POLY_TAP and stage POLY_LEN, where stage 1 holds the newest bit. The first bit computed lands in bit SAMPLE_W-1 and the last in bit 0. The register then holds the low POLY_LEN bits of that word. The word appears on gen_data after that edge, with gen_valid high.
- R4: On a clock with gen_en low, gen_data and the register keep their values and gen_valid is low. The sequence later resumes with no bits skipped.
- R5: The generator register never reaches all zeros, so every generated word is non-zero.
- R6: With the default pair (9,5) at width 14, the bit stream repeats every 511 bits. The 74th enabled word therefore equals the 1st.
- R7: The first valid word after reset seeds the checker state from that word's low POLY_LEN bits. chk_locked rises one clock later, and the seed word raises no error.
- R8: Once locked, each valid word is compared with the predicted next word. chk_err is high for exactly the clock after a word that differs, and low after a word that matches.
- R9: Each error pulse increments chk_err_count by one. The count stops at its all-ones value.
- R10: A mismatch that makes MISS_LIMIT mismatches in a row reseeds the state from that word and clears the streak. A matching word also clears the streak. Shorter bursts keep predicting from the old state.
- R11: On a clock with chk_valid low, chk_data is ignored. chk_err is low afterwards, the count is unchanged, and prediction resumes where it left off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| gen_en | input | 1 | Advance the generator by one word |
| gen_data | output | SAMPLE_W | Generated sequence word |
| gen_valid | output | 1 | gen_data was updated at the last edge |
| chk_valid | input | 1 | chk_data carries a word to check |
| chk_data | input | SAMPLE_W | Word under test |
| chk_locked | output | 1 | Checker has seeded its state |
| chk_err | output | 1 | Last checked word mismatched |
| chk_err_count | output | CNT_W | Saturating mismatch count |

## Verification
Every result is due one clock edge after its stimulus. A generated word and gen_valid follow the edge that sees gen_en. chk_err, chk_locked and chk_err_count follow the edge that sees chk_valid with its word. The bench drives all inputs on the falling edge and samples all outputs on the next falling edge, so each expectation is compared exactly one rising edge after it was applied. The bench's own models of the sequence and of the checker advance once per applied cycle, in step with that single edge.

// File: rtl/prbs_pkg.sv
package prbs_pkg;

  // Checker operating phase
  typedef enum logic {
    CHK_HUNT  = 1'b0,
    CHK_TRACK = 1'b1
  } chk_phase_e;

  // Legal (length, tap) pairs and width constraint
  function automatic bit pair_ok(int len, int tap, int width);
    bit p;
    case (len)
      7:       p = (tap == 6);
      9:       p = (tap == 5);
      15:      p = (tap == 14);
      23:      p = (tap == 18);
      31:      p = (tap == 28);
      default: p = 1'b0;
    endcase
    return p && (len <= width) && (width >= 12) && (width <= 16);
  endfunction

endpackage

// File: rtl/prbs_step.sv
// Combinational advance of the shift register by W bits.
module prbs_step #(
  parameter int W = 14,
  parameter int L = 9,
  parameter int T = 5
) (
  input  logic [L-1:0] cur,
  output logic [W-1:0] word,
  output logic [L-1:0] nxt
);

  // Stage k lives in bit k-1; stage 1 is the newest bit.
  function automatic logic [W-1:0] advance_word(logic [L-1:0] seed);
    logic [L-1:0] s;
    logic [W-1:0] acc;
    logic         b;
    s   = seed;
    acc = '0;
    for (int j = 0; j < W; j++) begin
      b   = s[T-1] ^ s[L-1];
      acc = {acc[W-2:0], b};
      s   = {s[L-2:0], b};
    end
    return acc;
  endfunction

  assign word = advance_word(cur);
  // L <= W: the newest L bits of the word are the new state
  assign nxt  = word[L-1:0];

endmodule

// File: rtl/prbs_gen.sv
module prbs_gen #(
  parameter int W = 14,
  parameter int L = 9,
  parameter int T = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  output logic [W-1:0] data,
  output logic         valid
);

  logic [L-1:0] state_q;
  logic [L-1:0] state_d;
  logic [W-1:0] word_d;
  logic [W-1:0] data_q;
  logic         valid_q;

  prbs_step #(.W(W), .L(L), .T(T)) u_step (
    .cur  (state_q),
    .word (word_d),
    .nxt  (state_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= '1;
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= en;
      if (en) begin
        state_q <= state_d;
        data_q  <= word_d;
      end
    end
  end

  assign data  = data_q;
  assign valid = valid_q;

  AST_GEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(state_q) && $stable(data_q));  // R4
  AST_GEN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0);  // R5

endmodule

// File: rtl/prbs_chk.sv
module prbs_chk #(
  parameter int W          = 14,
  parameter int L          = 9,
  parameter int T          = 5,
  parameter int MISS_LIMIT = 4,
  parameter int CNT_W      = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid,
  input  logic [W-1:0]     data,
  output logic             locked,
  output logic             err,
  output logic [CNT_W-1:0] err_cnt
);
  import prbs_pkg::*;

  localparam int MW = $clog2(MISS_LIMIT + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [MW-1:0]    LAST_MISS = MW'(MISS_LIMIT - 1);

  chk_phase_e     phase_q;
  logic [L-1:0]   state_q;
  logic [MW-1:0]  miss_q;
  logic           err_q;
  logic [CNT_W-1:0] cnt_q;

  logic [W-1:0]   pred_word;
  logic [L-1:0]   pred_state;

  prbs_step #(.W(W), .L(L), .T(T)) u_pred (
    .cur  (state_q),
    .word (pred_word),
    .nxt  (pred_state)
  );

  // Named events
  logic seed_evt, cmp_evt, miss_evt, streak_full, reseed_evt, hit_evt;
  assign seed_evt    = valid && (phase_q == CHK_HUNT);
  assign cmp_evt     = valid && (phase_q == CHK_TRACK);
  assign miss_evt    = cmp_evt && (data != pred_word);
  assign hit_evt     = cmp_evt && !miss_evt;
  assign streak_full = miss_evt && (miss_q == LAST_MISS);
  assign reseed_evt  = seed_evt || streak_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= CHK_HUNT;
      state_q <= '0;
      miss_q  <= '0;
      err_q   <= 1'b0;
      cnt_q   <= '0;
    end else begin
      err_q <= miss_evt;
      if (seed_evt)
        phase_q <= CHK_TRACK;
      if (reseed_evt)
        state_q <= data[L-1:0];
      else if (cmp_evt)
        state_q <= pred_state;
      if (streak_full || hit_evt)
        miss_q <= '0;
      else if (miss_evt)
        miss_q <= miss_q + 1'b1;
      if (miss_evt && (cnt_q != CNT_MAX))
        cnt_q <= cnt_q + 1'b1;
    end
  end

  assign locked  = (phase_q == CHK_TRACK);
  assign err     = err_q;
  assign err_cnt = cnt_q;

  AST_SEED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> !err_q);  // R7
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    err_q && ($past(cnt_q) != CNT_MAX) |-> cnt_q == $past(cnt_q) + 1'b1);  // R9
  AST_CNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cnt_q) == CNT_MAX) |-> cnt_q == CNT_MAX);  // R9
  AST_MISS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    miss_q < MW'(MISS_LIMIT));  // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |=> !err_q && $stable(cnt_q) && $stable(state_q));  // R11

endmodule

// File: rtl/prbs_gen_chk.sv
module prbs_gen_chk #(
  parameter int SAMPLE_W   = 14,
  parameter int POLY_LEN   = 9,
  parameter int POLY_TAP   = 5,
  parameter int MISS_LIMIT = 4,
  parameter int CNT_W      = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                gen_en,
  output logic [SAMPLE_W-1:0] gen_data,
  output logic                gen_valid,
  input  logic                chk_valid,
  input  logic [SAMPLE_W-1:0] chk_data,
  output logic                chk_locked,
  output logic                chk_err,
  output logic [CNT_W-1:0]    chk_err_count
);

  initial begin
    AST_LEGAL_CFG: assert (prbs_pkg::pair_ok(POLY_LEN, POLY_TAP, SAMPLE_W))
      else $error("prbs_gen_chk: illegal length/tap/width setting");  // R2
  end

  prbs_gen #(.W(SAMPLE_W), .L(POLY_LEN), .T(POLY_TAP)) u_gen (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (gen_en),
    .data  (gen_data),
    .valid (gen_valid)
  );

  prbs_chk #(
    .W(SAMPLE_W), .L(POLY_LEN), .T(POLY_TAP),
    .MISS_LIMIT(MISS_LIMIT), .CNT_W(CNT_W)
  ) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid   (chk_valid),
    .data    (chk_data),
    .locked  (chk_locked),
    .err     (chk_err),
    .err_cnt (chk_err_count)
  );

endmodule

// File: tb/prbs_gen_chk_tb_top.sv
module prbs_gen_chk_tb_top;
  localparam int W = 14, L = 9, T = 5, LIM = 4, CW = 4;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic gen_en = 1'b0;
  logic chk_valid = 1'b0;
  logic [W-1:0] chk_data = '0;
  logic [W-1:0] gen_data;
  logic gen_valid, chk_locked, chk_err;
  logic [CW-1:0] chk_err_count;

  always #4 clk = ~clk;  // 125 MHz

  prbs_gen_chk #(.SAMPLE_W(W), .POLY_LEN(L), .POLY_TAP(T),
                 .MISS_LIMIT(LIM), .CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .gen_en(gen_en), .gen_data(gen_data),
    .gen_valid(gen_valid), .chk_valid(chk_valid), .chk_data(chk_data),
    .chk_locked(chk_locked), .chk_err(chk_err), .chk_err_count(chk_err_count)
  );

  int n_chk = 0, n_bad = 0;

  // Bit history models: bit 0 is the newest bit, x[n] = x[n-T] ^ x[n-L]
  logic [63:0] g_hist, c_hist, f_hist;
  logic [W-1:0] g_last;
  bit c_lock;
  int c_miss, c_cnt, g_idx;
  logic [W-1:0] g_first;

  function automatic logic [W-1:0] draw(input logic [63:0] h, output logic [63:0] ho);
    logic [W-1:0] w;
    logic b;
    w = '0;
    for (int k = 0; k < W; k++) begin
      b = h[T-1] ^ h[L-1];
      w[W-1-k] = b;
      h = {h[62:0], b};
    end
    ho = h;
    return w;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(bit en, bit cv, logic [W-1:0] cd, string gtag, string ctag);
    logic [W-1:0] gexp, pw;
    bit eerr;
    gen_en = en; chk_valid = cv; chk_data = cd;
    if (en) begin gexp = draw(g_hist, g_hist); g_last = gexp; end
    else gexp = g_last;
    eerr = 1'b0;
    if (cv) begin
      if (!c_lock) begin c_hist = 64'(cd); c_lock = 1'b1; end
      else begin
        pw = draw(c_hist, c_hist);
        if (pw == cd) c_miss = 0;
        else begin
          eerr = 1'b1;
          if (c_cnt < CMAX) c_cnt++;
          c_miss++;
          if (c_miss == LIM) begin c_hist = 64'(cd); c_miss = 0; end
        end
      end
    end
    @(posedge clk);
    @(negedge clk);
    check({gtag, " gen_data"}, 32'(gen_data), 32'(gexp));
    check({gtag, " gen_valid"}, 32'(gen_valid), 32'(en));
    if (en) check("R5 nonzero word", 32'(gen_data != 0), 32'd1);
    check({ctag, " chk_err"}, 32'(chk_err), 32'(eerr));
    check({ctag, " chk_locked"}, 32'(chk_locked), 32'(c_lock));
    check("R9 chk_err_count", 32'(chk_err_count), 32'(c_cnt));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog R1 actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [W-1:0] w;
    bit en;
    bit first;
    g_hist = '1; f_hist = 64'h0000_0000_0000_00A5;
    c_hist = '0; c_lock = 1'b0; c_miss = 0; c_cnt = 0; g_idx = 0;
    g_last = '0; g_first = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 gen_data", 32'(gen_data), 0);
    check("R1 gen_valid", 32'(gen_valid), 0);
    check("R1 chk_locked", 32'(chk_locked), 0);
    check("R1 chk_err", 32'(chk_err), 0);
    check("R1 chk_err_count", 32'(chk_err_count), 0);
    rst_n = 1'b1;

    // Generator sweep with gaps; checker fed a clean stream with the same gaps
    first = 1'b1;
    for (int i = 0; i < 600; i++) begin
      en = (i % 5) != 4;
      if (en) w = draw(f_hist, f_hist); else w = 14'h2AAA;
      tick(en, en, w,
           en ? (g_idx == 0 ? "R1 seed word" : "R3 step") : "R4 hold",
           en ? (first ? "R7 seed" : "R8 match") : "R11 idle");
      if (en) begin
        first = 1'b0;
        if (g_idx == 0) g_first = gen_data;
        if (g_idx == 73) check("R6 period", 32'(gen_data), 32'(g_first));
        g_idx++;
      end
    end

    // Single-bit errors at every position
    for (int b = 0; b < W; b++) begin
      tick(1'b0, 1'b1, draw(f_hist, f_hist), "R4 hold", "R8 match");
      w = draw(f_hist, f_hist) ^ (W'(1) << b);
      tick(1'b0, 1'b1, w, "R4 hold", "R8 flip");
      tick(1'b0, 1'b0, w, "R4 hold", "R11 idle");
      tick(1'b0, 1'b1, draw(f_hist, f_hist), "R4 hold", "R8 recover");
    end

    // Bursts of mismatches of increasing length
    for (int n = 1; n <= LIM + 1; n++) begin
      for (int k = 0; k < n; k++)
        tick(1'b0, 1'b1, draw(f_hist, f_hist) ^ W'(1), "R4 hold", "R10 burst");
      for (int k = 0; k < 10; k++)
        tick(1'b0, 1'b1, draw(f_hist, f_hist), "R4 hold", "R10 after burst");
    end

    // Explicit reseed: stream continues from the last of LIM bad words
    for (int k = 0; k < LIM; k++) begin
      w = ~draw(f_hist, f_hist);
      tick(1'b0, 1'b1, w, "R4 hold", "R10 bad run");
    end
    f_hist = 64'(w);
    for (int k = 0; k < 6; k++)
      tick(1'b0, 1'b1, draw(f_hist, f_hist), "R4 hold", "R10 reseeded");
    check("R10 reseed no error", 32'(chk_err), 0);

    // Saturation of the error count
    for (int k = 0; k < 40; k++)
      tick(1'b0, 1'b1, ~draw(f_hist, f_hist), "R4 hold", "R9 garbage");
    check("R9 saturated", 32'(chk_err_count), 32'(CMAX));
    tick(1'b0, 1'b0, '0, "R4 hold", "R11 idle");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule